// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block evaluates a relation between two single-precision IEEE-754 operands and produces a one-bit condition flag for the processor status. A decoded 8-bit secondary opcode selects one compare from the compare group. The caller presents the opcode and both operands with a valid strobe. One clock later the unit drives the new flag value and a write enable for the status bit. A compare never produces a register result.

There are six relations: equal, not equal, greater, greater-or-equal, less and less-or-equal. Each relation has two forms. The ordered form treats any NaN input as making the relation false, except for not-equal, which becomes true. The unordered-or form sets the flag when either operand is NaN or when the relation holds. A separate opcode tests only whether the operand pair is unordered. Any other opcode is ignored: the write enable stays low and the flag keeps its value.

Top module: `fcmp_flag_unit`

## Requirements
- R1: After reset, `flag_we` is 0 and `flag` is 0.
- R2: When `op_valid` is high with a listed opcode at a rising edge, `flag_we` is 1 and `flag` holds the result for exactly the following cycle.
- R3: Opcodes 0x08, 0x09, 0x0A, 0x0B, 0x0C and 0x0D select the ordered relations equal, not-equal, greater, greater-or-equal, less and less-or-equal, with operand A on the left of the relation.
- R4: Opcodes 0x28 to 0x2D select the same six relations in the same order, in unordered-or form. The flag is 1 when either operand is NaN or when the relation holds.
- R5: Opcode 0x2E sets the flag to 1 only when at least one operand is NaN. A NaN has an exponent field (bits 30:23) of all ones and a nonzero fraction (bits 22:0), and this includes signalling NaNs.
- R6: For an ordered compare with a NaN operand, the flag is 0 for every relation except not-equal, which gives 1.
- R7: Positive zero and negative zero compare as equal, and neither one is less than the other.
- R8: Operands that are not NaN are ordered by their real value, including infinities and denormals. Exactly one of less, equal and greater holds.
- R9: An opcode outside the listed set leaves `flag_we` at 0 in the following cycle and does not change `flag`.
- R10: While `op_valid` is low, `flag_we` is 0 and `flag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe for one compare |
| op_code | input | 8 | Secondary opcode of the request |
| op_a | input | 32 | Left operand, single precision |
| op_b | input | 32 | Right operand, single precision |
| flag | output | 1 | Condition flag register |
| flag_we | output | 1 | Status-flag write enable, one cycle after the request |

## Verification
The hardest case to reach is an illegal opcode whose effect must be seen through a flag that would not have changed anyway. Before each such request, the bench sets the flag to a known value with a legal compare, and it picks that value as the opposite of what a wrong write would leave. It then sweeps all 256 opcodes over operand pairs that include quiet and signalling NaNs, both infinities, both zeros and denormals of either sign. Each result is checked against a model that maps operands to signed integer keys.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned MAG_W  = WORD_W - 1;
  localparam int unsigned OPC_W  = 8;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_GT = 3'd2,
    REL_GE = 3'd3,
    REL_LT = 3'd4,
    REL_LE = 3'd5,
    REL_UN = 3'd6
  } rel_e;

  // NaN: all-ones exponent and nonzero fraction
  function automatic logic word_is_nan(input logic [WORD_W-1:0] w);
    return (&w[WORD_W-2 -: EXP_W]) && (|w[FRAC_W-1:0]);
  endfunction

  function automatic logic word_is_zero(input logic [WORD_W-1:0] w);
    return ~|w[MAG_W-1:0];
  endfunction

  // Sign-magnitude less-than for non-NaN words; +0 and -0 are equal
  function automatic logic sm_less(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b);
    logic sa, sb;
    sa = a[WORD_W-1];
    sb = b[WORD_W-1];
    if (word_is_zero(a) && word_is_zero(b)) return 1'b0;
    if (sa != sb) return sa;
    if (sa) return a[MAG_W-1:0] > b[MAG_W-1:0];
    return a[MAG_W-1:0] < b[MAG_W-1:0];
  endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              is_nan,
  output logic              is_zero
);
  assign is_nan  = word_is_nan(word);
  assign is_zero = word_is_zero(word);
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
  import fcmp_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              zero_pair,
  output logic              lt,
  output logic              eq,
  output logic              gt
);
  // Meaningful only when neither operand is NaN
  assign eq = zero_pair || (a == b);
  assign lt = sm_less(a, b);
  assign gt = sm_less(b, a);
endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output logic             legal,
  output logic             unord_or,
  output rel_e             rel
);
  always_comb begin
    legal    = 1'b0;
    unord_or = 1'b0;
    rel      = REL_EQ;
    unique case (opc)
      8'h08: begin legal = 1'b1; rel = REL_EQ; end
      8'h09: begin legal = 1'b1; rel = REL_NE; end
      8'h0A: begin legal = 1'b1; rel = REL_GT; end
      8'h0B: begin legal = 1'b1; rel = REL_GE; end
      8'h0C: begin legal = 1'b1; rel = REL_LT; end
      8'h0D: begin legal = 1'b1; rel = REL_LE; end
      8'h28: begin legal = 1'b1; unord_or = 1'b1; rel = REL_EQ; end
      8'h29: begin legal = 1'b1; unord_or = 1'b1; rel = REL_NE; end
      8'h2A: begin legal = 1'b1; unord_or = 1'b1; rel = REL_GT; end
      8'h2B: begin legal = 1'b1; unord_or = 1'b1; rel = REL_GE; end
      8'h2C: begin legal = 1'b1; unord_or = 1'b1; rel = REL_LT; end
      8'h2D: begin legal = 1'b1; unord_or = 1'b1; rel = REL_LE; end
      8'h2E: begin legal = 1'b1; rel = REL_UN; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              flag,
  output logic              flag_we
);
  logic a_nan, a_zero, b_nan, b_zero;
  logic any_nan, zero_pair;
  logic r_lt, r_eq, r_gt;
  logic dec_legal, dec_uo;
  rel_e dec_rel;
  logic rel_hold, ord_result, flag_next, accept;

  fcmp_classify cls_a_i (.word(op_a), .is_nan(a_nan), .is_zero(a_zero));
  fcmp_classify cls_b_i (.word(op_b), .is_nan(b_nan), .is_zero(b_zero));

  assign any_nan   = a_nan | b_nan;
  assign zero_pair = a_zero & b_zero;

  fcmp_relation rel_i (
    .a(op_a), .b(op_b), .zero_pair(zero_pair),
    .lt(r_lt), .eq(r_eq), .gt(r_gt)
  );

  fcmp_decode dec_i (
    .opc(op_code), .legal(dec_legal), .unord_or(dec_uo), .rel(dec_rel)
  );

  always_comb begin
    unique case (dec_rel)
      REL_EQ:  rel_hold = r_eq;
      REL_NE:  rel_hold = !r_eq;
      REL_GT:  rel_hold = r_gt;
      REL_GE:  rel_hold = r_gt | r_eq;
      REL_LT:  rel_hold = r_lt;
      REL_LE:  rel_hold = r_lt | r_eq;
      default: rel_hold = 1'b0;
    endcase
  end

  // Ordered: NaN forces false except not-equal which is forced true
  assign ord_result = any_nan ? (dec_rel == REL_NE) : rel_hold;

  always_comb begin
    if (dec_rel == REL_UN)
      flag_next = any_nan;
    else if (dec_uo)
      flag_next = any_nan | rel_hold;
    else
      flag_next = ord_result;
  end

  assign accept = op_valid & dec_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      flag_we <= 1'b0;
    end else begin
      flag_we <= accept;
      if (accept) flag <= flag_next;
    end
  end

  a_r2_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flag_we);
  a_r9_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dec_legal) |=> (!flag_we && $stable(flag)));
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!flag_we && $stable(flag)));
  a_r5_unordered_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 8'h2E && any_nan) |=> flag);
  a_r6_ordered_eq_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 8'h08 && any_nan) |=> !flag);
  a_r7_zeros_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_pair && !any_nan) |-> (r_eq && !r_lt && !r_gt));
  a_r8_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
    !any_nan |-> $onehot({r_lt, r_eq, r_gt}));
endmodule

// File: tb/fcmp_flag_unit_tb_top.sv
module fcmp_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 22;
  localparam int NPAIR      = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [31:0] op_a = 32'h0, op_b = 32'h0;
  logic flag, flag_we;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .flag(flag), .flag_we(flag_we)
  );

  // {opcode, a, b, expected flag}
  localparam logic [72:0] VEC [NVEC] = '{
    {8'h08, 32'h00000000, 32'h80000000, 1'b1},
    {8'h09, 32'h00000000, 32'h80000000, 1'b0},
    {8'h0A, 32'h40000000, 32'h3F800000, 1'b1},
    {8'h0A, 32'hC0000000, 32'hBF800000, 1'b0},
    {8'h0C, 32'hC0000000, 32'hBF800000, 1'b1},
    {8'h0B, 32'h3F800000, 32'h3F800000, 1'b1},
    {8'h0D, 32'h7F800000, 32'h3F800000, 1'b0},
    {8'h0C, 32'hFF800000, 32'h80000001, 1'b1},
    {8'h0A, 32'h00000001, 32'h00000000, 1'b1},
    {8'h0C, 32'h80000001, 32'h00000000, 1'b1},
    {8'h08, 32'h7FC00000, 32'h7FC00000, 1'b0},
    {8'h09, 32'h7FC00000, 32'h3F800000, 1'b1},
    {8'h0B, 32'h7F800001, 32'h3F800000, 1'b0},
    {8'h0D, 32'h3F800000, 32'h7FC00000, 1'b0},
    {8'h28, 32'h7FC00000, 32'h3F800000, 1'b1},
    {8'h28, 32'h3F800000, 32'h3F800000, 1'b1},
    {8'h2A, 32'h3F800000, 32'h40000000, 1'b0},
    {8'h2C, 32'h80000000, 32'h00000000, 1'b0},
    {8'h2D, 32'h80000000, 32'h00000000, 1'b1},
    {8'h2E, 32'h3F800000, 32'hFFC00000, 1'b1},
    {8'h2E, 32'h7F800000, 32'hFF800000, 1'b0},
    {8'h29, 32'h00000000, 32'h80000000, 1'b0}
  };

  localparam logic [31:0] PAIRS [NPAIR][2] = '{
    '{32'h3F800000, 32'h40000000}, '{32'h40000000, 32'h3F800000},
    '{32'hBF800000, 32'hBF800000}, '{32'h00000000, 32'h80000000},
    '{32'h7FC00000, 32'h3F800000}, '{32'h3F800000, 32'h7F800001},
    '{32'h7F800000, 32'hFF800000}, '{32'h80000001, 32'h00000001},
    '{32'h007FFFFF, 32'h00800000}, '{32'hC0000000, 32'h3F800000},
    '{32'hFFFFFFFF, 32'hFFFFFFFF}, '{32'hFF800000, 32'hC0000000}
  };

  function automatic logic m_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  // Signed integer key: order of keys equals order of values
  function automatic longint m_key(input logic [31:0] w);
    longint mag;
    mag = longint'(w[30:0]);
    return w[31] ? -mag : mag;
  endfunction

  function automatic logic m_legal(input logic [7:0] op);
    return (op >= 8'h08 && op <= 8'h0D) || (op >= 8'h28 && op <= 8'h2E);
  endfunction

  function automatic logic m_eval(input logic [7:0] op, input logic [31:0] a,
                                  input logic [31:0] b);
    logic un, r;
    longint ka, kb;
    un = m_nan(a) || m_nan(b);
    ka = m_key(a);
    kb = m_key(b);
    if (op == 8'h2E) return un;
    case (op[2:0])
      3'd0: r = (ka == kb);
      3'd1: r = (ka != kb);
      3'd2: r = (ka > kb);
      3'd3: r = (ka >= kb);
      3'd4: r = (ka < kb);
      default: r = (ka <= kb);
    endcase
    if (un) r = (op[5] == 1'b1) ? 1'b1 : (op[2:0] == 3'd1);
    return r;
  endfunction

  task automatic check(input string req, input logic act, input logic expv,
                       input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
    end
  endtask

  // Drive at falling edge, rising edge captures, sample at the next falling edge
  task automatic issue(input logic v, input logic [7:0] op, input logic [31:0] a,
                       input logic [31:0] b);
    op_valid = v; op_code = op; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [7:0] op,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic expv);
    issue(1'b1, op, a, b);
    if (m_legal(op)) exp_flag = expv;
    check(req, flag_we, m_legal(op), $sformatf("we op=%h", op));
    check(req, flag, exp_flag, $sformatf("flag op=%h a=%h b=%h", op, a, b));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    check("R1", flag, 1'b0, "flag in reset");
    check("R1", flag_we, 1'b0, "we in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R8 table
    for (int i = 0; i < NVEC; i++) begin
      run_op("R3/R4/R5/R6/R7/R8", VEC[i][72:65], VEC[i][64:33], VEC[i][32:1],
             VEC[i][0]);
      check("R8", VEC[i][0], m_eval(VEC[i][72:65], VEC[i][64:33], VEC[i][32:1]),
            "table vs model");
    end

    // R2: write enable lasts exactly one cycle
    run_op("R2", 8'h0A, 32'h40000000, 32'h3F800000, 1'b1);
    @(negedge clk);
    check("R2", flag_we, 1'b0, "we drops after one cycle");

    // Sweep every opcode; pre-set the flag opposite to the model result
    for (int op = 0; op < 256; op++) begin
      for (int p = 0; p < NPAIR; p++) begin
        logic e;
        e = m_eval(8'(op), PAIRS[p][0], PAIRS[p][1]);
        if (e) run_op("R2", 8'h09, 32'h0, 32'h0, 1'b0);
        else   run_op("R2", 8'h08, 32'h0, 32'h0, 1'b1);
        run_op(m_legal(8'(op)) ? "R3/R4/R5" : "R9", 8'(op), PAIRS[p][0],
               PAIRS[p][1], e);
      end
    end

    // R10: idle with operands that would flip the flag
    run_op("R10", 8'h08, 32'h3F800000, 32'h3F800000, 1'b1);
    issue(1'b0, 8'h09, 32'h3F800000, 32'h3F800000);
    check("R10", flag_we, 1'b0, "we while idle");
    check("R10", flag, 1'b1, "flag while idle");

    // R9: illegal opcode next to the compare group
    issue(1'b1, 8'h0E, 32'h3F800000, 32'h40000000);
    check("R9", flag_we, 1'b0, "we illegal 0E");
    check("R9", flag, 1'b1, "flag illegal 0E");
    issue(1'b1, 8'h2F, 32'h7FC00000, 32'h0);
    check("R9", flag, 1'b1, "flag illegal 2F");

    // R1: reset in mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", flag, 1'b0, "flag after second reset");
    check("R1", flag_we, 1'b0, "we after second reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule